// File: doc/BRIEF.md
# SerDes Lane Setting Steering and Power Sequencer

This block sits on the configuration side of a four-lane SerDes group. Software writes one of four per-lane setting registers: transmit setting A, transmit setting B, receive setting and receive equaliser setting. A lane-target field in a control word decides where the write lands. It can reach a single lane, every lane in the same clock, or no lane at all when the code is reserved. Each setting register also keeps a shadow of the last value written to it. Reads return that shadow, whatever the lane target is at the time.

The same control word holds a power-down bit. A small state machine drives the lane low-power (P2) outputs, the clock multiplier power-down and a force-to-Detect request toward the link training state machine. When power returns, the state machine waits a programmable number of cycles, then waits for the clock multiplier lock report, and then issues a one-cycle link-training request. An external hold input marks the group as already held down by other means. While the hold is active the power-down bit does nothing.

The state machine has five states:

| State | Meaning |
|-------|---------|
| PW_WAKE | Powering up, counting and waiting for lock |
| PW_TRAIN | One-cycle training request |
| PW_UP | Running |
| PW_DOWN | Powered down by the control bit |
| PW_HELD | Held down by the external input |

Transitions:
- Any state other than PW_HELD goes to PW_HELD when the hold rises.
- PW_HELD goes to PW_DOWN when the hold is released with the bit set, and to PW_WAKE when it is released with the bit clear.
- Any non-held state goes to PW_DOWN when the bit is set.
- PW_DOWN goes to PW_WAKE when the bit is cleared.
- PW_WAKE goes to PW_TRAIN once the count is complete and lock is seen.
- PW_TRAIN goes to PW_UP.
- Reset enters PW_WAKE.

Top module: `serdes_lane_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x00000010. Every lane setting output and every setting shadow is zero. The power state is PW_WAKE: lane_p2, cmu_pd and force_detect are low.
- R2: With lane target 0 to 3 (control bits 4:0), a write to setting address 1 (tx A), 2 (tx B), 3 (rx) or 4 (rx eq) updates only that lane's field of that kind, visible after the write's clock edge. Lane n occupies bits n*16+15 down to n*16 of its output. All other fields keep their values.
- R3: With lane target 0x10, a setting write updates all four lanes of that kind at the same edge.
- R4: A read of addresses 1 to 4 returns the low 16 bits of the last value written there, zero-extended. The current lane target does not change the result.
- R5: With any other lane target, a setting write changes no lane output. Its shadow is still updated.
- R6: The control word returns the lane target in bits 4:0 and the power-down bit in bit 5. Bits 31:6 read as zero. Addresses 5 to 7 read zero, and writes to them change nothing.
- R7: A control write that sets the power-down bit, without hold, makes lane_p2 all ones, cmu_pd high and force_detect high from the next edge. train_req stays low.
- R8: A control write that clears the bit moves the machine to PW_WAKE at the next edge. From there lane_p2, cmu_pd and force_detect are low. With lock held high, train_req goes high for exactly one cycle, WAKE_CYCLES edges after entry.
- R9: While cmu_lock is low, train_req stays low however long the wait lasts. After the count is complete, train_req pulses one cycle after lock is seen.
- R10: While ext_hold is high, lane_p2 and cmu_pd are high and force_detect and train_req are low. Power-down writes have no effect on these outputs. On release the machine enters PW_DOWN if the bit is set, and PW_WAKE otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| ext_hold | input | 1 | Group held down by other means |
| cmu_lock | input | 1 | Clock multiplier lock report |
| lane_tx0 | output | 64 | Transmit setting A, four lanes |
| lane_tx1 | output | 64 | Transmit setting B, four lanes |
| lane_rx | output | 64 | Receive setting, four lanes |
| lane_rxeq | output | 64 | Receive equaliser setting, four lanes |
| lane_p2 | output | 4 | Per-lane P2 low-power request |
| cmu_pd | output | 1 | Clock multiplier power-down |
| force_detect | output | 1 | Force link training to Detect |
| train_req | output | 1 | One-cycle link training start |

## Verification
Every one of the 32 lane-target codes is combined with every setting kind, using data that differs per pair. This sweep tells single-lane steering apart from broadcast and from reserved codes. It also tells a kind that was hit apart from its neighbours, and shadow reads apart from lane contents. The power sequence is driven twice, once with lock held low for twice the wait and once with lock high. Together the two runs separate the count from the lock condition and confirm the exact pulse cycle. Hold is raised while power-down writes arrive, to show that they have no effect and that release leads to the right state.

// File: rtl/serdes_lane_pkg.sv
package serdes_lane_pkg;
    localparam int          SEL_W   = 5;
    localparam logic [4:0]  SEL_ALL = 5'h10;
    localparam int          ADDR_W  = 3;
    localparam int          NKIND   = 4;
    localparam logic [2:0]  A_CTRL  = 3'd0;
    localparam logic [2:0]  A_TX0   = 3'd1;
    localparam logic [2:0]  A_TX1   = 3'd2;
    localparam logic [2:0]  A_RX    = 3'd3;
    localparam logic [2:0]  A_RXEQ  = 3'd4;
    localparam int          PD_BIT  = 5;

    typedef enum logic [2:0] {
        PW_WAKE,
        PW_TRAIN,
        PW_UP,
        PW_DOWN,
        PW_HELD
    } pwr_state_e;
endpackage

// File: rtl/lane_cfg_regs.sv
module lane_cfg_regs
    import serdes_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SET_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    output logic [SEL_W-1:0]    lane_sel,
    output logic                pwrdn_nxt,
    output logic [NKIND-1:0]    kind_we
);
    logic [SEL_W-1:0] sel_q;
    logic             pwrdn_q;
    logic [SET_W-1:0] shadow_q [NKIND];
    logic             ctrl_we;

    assign ctrl_we   = cfg_we && (cfg_addr == A_CTRL);
    assign pwrdn_nxt = ctrl_we ? cfg_wdata[PD_BIT] : pwrdn_q;
    assign lane_sel  = sel_q;

    // One-hot kind strobe: addresses 1..NKIND map to kinds 0..NKIND-1
    for (genvar k = 0; k < NKIND; k++) begin : g_kwe
        assign kind_we[k] = cfg_we && (cfg_addr == ADDR_W'(k + 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= SEL_ALL;
            pwrdn_q <= 1'b0;
        end else if (ctrl_we) begin
            sel_q   <= cfg_wdata[SEL_W-1:0];
            pwrdn_q <= cfg_wdata[PD_BIT];
        end
    end

    for (genvar k = 0; k < NKIND; k++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n)          shadow_q[k] <= '0;
            else if (kind_we[k]) shadow_q[k] <= cfg_wdata[SET_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == A_CTRL) begin
            cfg_rdata[SEL_W-1:0] = sel_q;
            cfg_rdata[PD_BIT]    = pwrdn_q;
        end else if (cfg_addr <= ADDR_W'(NKIND)) begin
            cfg_rdata[SET_W-1:0] = shadow_q[cfg_addr - 1'b1];
        end
    end
endmodule

// File: rtl/lane_setting_bank.sv
module lane_setting_bank
    import serdes_lane_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int SET_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NKIND-1:0]         kind_we,
    input  logic [SET_W-1:0]         set_data,
    input  logic [SEL_W-1:0]         lane_sel,
    output logic [NLANES*SET_W-1:0]  lane_tx0,
    output logic [NLANES*SET_W-1:0]  lane_tx1,
    output logic [NLANES*SET_W-1:0]  lane_rx,
    output logic [NLANES*SET_W-1:0]  lane_rxeq
);
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic                        hit;
        logic [NKIND-1:0][SET_W-1:0] val_q;

        // Reserved codes match no lane and are not broadcast
        assign hit = (lane_sel == SEL_ALL) || (lane_sel == SEL_W'(l));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else begin
                for (int k = 0; k < NKIND; k++) begin
                    if (kind_we[k] && hit) val_q[k] <= set_data;
                end
            end
        end

        assign lane_tx0 [l*SET_W +: SET_W] = val_q[0];
        assign lane_tx1 [l*SET_W +: SET_W] = val_q[1];
        assign lane_rx  [l*SET_W +: SET_W] = val_q[2];
        assign lane_rxeq[l*SET_W +: SET_W] = val_q[3];
    end
endmodule

// File: rtl/serdes_pwr_fsm.sv
module serdes_pwr_fsm
    import serdes_lane_pkg::*;
#(
    parameter int NLANES      = 4,
    parameter int WAKE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn,
    input  logic              ext_hold,
    input  logic              cmu_lock,
    output logic [NLANES-1:0] lane_p2,
    output logic              cmu_pd,
    output logic              force_detect,
    output logic              train_req
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

    pwr_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wait_done;

    assign wait_done = (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PW_WAKE;
        else        st_q <= st_d;
    end

    // Wake counter: zero outside PW_WAKE, saturates at the last count
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != PW_WAKE) cnt_q <= '0;
        else if (!wait_done)           cnt_q <= cnt_q + 1'b1;
    end

    // Next state: hold beats the power-down bit, which beats sequencing
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PW_HELD: if (!ext_hold) st_d = pwrdn ? PW_DOWN : PW_WAKE;
            PW_WAKE: begin
                if (ext_hold)                  st_d = PW_HELD;
                else if (pwrdn)                st_d = PW_DOWN;
                else if (wait_done && cmu_lock) st_d = PW_TRAIN;
            end
            PW_TRAIN: begin
                if (ext_hold)   st_d = PW_HELD;
                else if (pwrdn) st_d = PW_DOWN;
                else            st_d = PW_UP;
            end
            PW_UP: begin
                if (ext_hold)   st_d = PW_HELD;
                else if (pwrdn) st_d = PW_DOWN;
            end
            PW_DOWN: begin
                if (ext_hold)    st_d = PW_HELD;
                else if (!pwrdn) st_d = PW_WAKE;
            end
            default: st_d = PW_WAKE;
        endcase
    end

    // Outputs
    always_comb begin
        lane_p2      = '0;
        cmu_pd       = 1'b0;
        force_detect = 1'b0;
        train_req    = 1'b0;
        unique case (st_q)
            PW_DOWN: begin
                lane_p2      = '1;
                cmu_pd       = 1'b1;
                force_detect = 1'b1;
            end
            PW_HELD: begin
                lane_p2 = '1;
                cmu_pd  = 1'b1;
            end
            PW_TRAIN: train_req = 1'b1;
            PW_WAKE, PW_UP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/serdes_lane_ctrl.sv
module serdes_lane_ctrl
    import serdes_lane_pkg::*;
#(
    parameter int NLANES      = 4,
    parameter int SET_W       = 16,
    parameter int DATA_W      = 32,
    parameter int WAKE_CYCLES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [DATA_W-1:0]        cfg_wdata,
    output logic [DATA_W-1:0]        cfg_rdata,
    input  logic                     ext_hold,
    input  logic                     cmu_lock,
    output logic [NLANES*SET_W-1:0]  lane_tx0,
    output logic [NLANES*SET_W-1:0]  lane_tx1,
    output logic [NLANES*SET_W-1:0]  lane_rx,
    output logic [NLANES*SET_W-1:0]  lane_rxeq,
    output logic [NLANES-1:0]        lane_p2,
    output logic                     cmu_pd,
    output logic                     force_detect,
    output logic                     train_req
);
    logic [SEL_W-1:0] lane_sel;
    logic             pwrdn_nxt;
    logic [NKIND-1:0] kind_we;

    lane_cfg_regs #(.DATA_W(DATA_W), .SET_W(SET_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lane_sel  (lane_sel),
        .pwrdn_nxt (pwrdn_nxt),
        .kind_we   (kind_we)
    );

    lane_setting_bank #(.NLANES(NLANES), .SET_W(SET_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind_we   (kind_we),
        .set_data  (cfg_wdata[SET_W-1:0]),
        .lane_sel  (lane_sel),
        .lane_tx0  (lane_tx0),
        .lane_tx1  (lane_tx1),
        .lane_rx   (lane_rx),
        .lane_rxeq (lane_rxeq)
    );

    serdes_pwr_fsm #(.NLANES(NLANES), .WAKE_CYCLES(WAKE_CYCLES)) pwr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwrdn        (pwrdn_nxt),
        .ext_hold     (ext_hold),
        .cmu_lock     (cmu_lock),
        .lane_p2      (lane_p2),
        .cmu_pd       (cmu_pd),
        .force_detect (force_detect),
        .train_req    (train_req)
    );
endmodule

// File: rtl/serdes_lane_ctrl_chk.sv
module serdes_lane_ctrl_chk
    import serdes_lane_pkg::*;
#(
    parameter int NLANES = 4,
    parameter int SET_W  = 16,
    parameter int DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cfg_we,
    input logic [2:0]               cfg_addr,
    input logic [DATA_W-1:0]        cfg_wdata,
    input logic [DATA_W-1:0]        cfg_rdata,
    input logic                     ext_hold,
    input logic                     cmu_lock,
    input logic [NLANES*SET_W-1:0]  lane_tx0,
    input logic [NLANES*SET_W-1:0]  lane_tx1,
    input logic [NLANES*SET_W-1:0]  lane_rx,
    input logic [NLANES*SET_W-1:0]  lane_rxeq,
    input logic [NLANES-1:0]        lane_p2,
    input logic                     cmu_pd,
    input logic                     force_detect,
    input logic                     train_req,
    input logic [SEL_W-1:0]         lane_sel
);
    logic set_wr, sel_reserved;
    assign set_wr       = cfg_we && cfg_addr >= A_TX0 && cfg_addr <= A_RXEQ;
    assign sel_reserved = (lane_sel >= SEL_W'(NLANES)) && (lane_sel != SEL_ALL);

    for (genvar l = 0; l < NLANES; l++) begin : g_one
        assert_single_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == A_TX0 && lane_sel == SEL_W'(l))
            |=> lane_tx0[l*SET_W +: SET_W] == $past(cfg_wdata[SET_W-1:0]));
    end

    assert_broadcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_RXEQ && lane_sel == SEL_ALL)
        |=> lane_rxeq == {NLANES{$past(cfg_wdata[SET_W-1:0])}});

    assert_shadow_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_RX)
        |=> (cfg_addr != A_RX || cfg_rdata == DATA_W'($past(cfg_wdata[SET_W-1:0]))));

    assert_reserved_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && sel_reserved)
        |=> $stable(lane_tx0) && $stable(lane_tx1) && $stable(lane_rx) && $stable(lane_rxeq));

    assert_ro_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == A_CTRL) |-> cfg_rdata[DATA_W-1:PD_BIT+1] == '0);

    assert_down_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_CTRL && cfg_wdata[PD_BIT] && !ext_hold)
        |=> force_detect && cmu_pd && (&lane_p2) && !train_req);

    assert_train_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        train_req |=> !train_req);

    assert_train_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_req) |-> $past(cmu_lock));

    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hold |=> !force_detect && !train_req && cmu_pd && (&lane_p2));
endmodule

bind serdes_lane_ctrl serdes_lane_ctrl_chk #(
    .NLANES(NLANES), .SET_W(SET_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_hold(ext_hold),
    .cmu_lock(cmu_lock), .lane_tx0(lane_tx0), .lane_tx1(lane_tx1),
    .lane_rx(lane_rx), .lane_rxeq(lane_rxeq), .lane_p2(lane_p2),
    .cmu_pd(cmu_pd), .force_detect(force_detect), .train_req(train_req),
    .lane_sel(lane_sel)
);

// File: tb/serdes_lane_ctrl_tb_top.sv
module serdes_lane_ctrl_tb_top;
    localparam int NL = 4;
    localparam int SW = 16;
    localparam int DW = 32;
    localparam int WC = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [2:0]     cfg_addr = '0;
    logic [DW-1:0]  cfg_wdata = '0;
    logic [DW-1:0]  cfg_rdata;
    logic           ext_hold = 1'b0;
    logic           cmu_lock = 1'b1;
    logic [NL*SW-1:0] lane_tx0, lane_tx1, lane_rx, lane_rxeq;
    logic [NL-1:0]  lane_p2;
    logic           cmu_pd, force_detect, train_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [SW-1:0] m_lane [4][NL];
    logic [SW-1:0] m_sh   [4];

    always #10 clk = ~clk;

    serdes_lane_ctrl #(.NLANES(NL), .SET_W(SW), .DATA_W(DW), .WAKE_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_hold(ext_hold),
        .cmu_lock(cmu_lock), .lane_tx0(lane_tx0), .lane_tx1(lane_tx1),
        .lane_rx(lane_rx), .lane_rxeq(lane_rxeq), .lane_p2(lane_p2),
        .cmu_pd(cmu_pd), .force_detect(force_detect), .train_req(train_req)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [63:0] kind_out(input int k);
        case (k)
            0: return lane_tx0;
            1: return lane_tx1;
            2: return lane_rx;
            default: return lane_rxeq;
        endcase
    endfunction

    function automatic logic [63:0] model_flat(input int k);
        logic [63:0] f;
        for (int l = 0; l < NL; l++) f[l*SW +: SW] = m_lane[k][l];
        return f;
    endfunction

    task automatic check_all(input string req);
        logic [DW-1:0] r;
        for (int k = 0; k < 4; k++) begin
            check(req, kind_out(k), model_flat(k));
            rd(3'(k + 1), r);
            check("R4 shadow", 64'(r), 64'(m_sh[k]));
        end
    endtask

    task automatic pwr_check(input string req, input logic [3:0] p2,
                             input logic pd, input logic fd, input logic tr);
        check(req, {57'b0, p2, pd, fd, tr}, {57'b0, p2, pd, fd, tr} ^ {57'b0, lane_p2 ^ p2,
              cmu_pd ^ pd, force_detect ^ fd, train_req ^ tr});
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] r;
        for (int k = 0; k < 4; k++) begin
            m_sh[k] = '0;
            for (int l = 0; l < NL; l++) m_lane[k][l] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd0, r);
        check("R1 ctrl", 64'(r), 64'h10);
        check_all("R1 lanes");
        pwr_check("R1 power", 4'h0, 1'b0, 1'b0, 1'b0);

        // R2 R3 R5: every kind with every select code
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 32; s++) begin
                logic [DW-1:0] d;
                d = DW'((k * 4099 + s * 257 + 17) * 40503);
                wr(3'd0, DW'(s));
                rd(3'd0, r);
                check("R6 sel readback", 64'(r), 64'(s));
                wr(3'(k + 1), d);
                m_sh[k] = d[SW-1:0];
                if (s == 16) begin
                    for (int l = 0; l < NL; l++) m_lane[k][l] = d[SW-1:0];
                end else if (s < NL) begin
                    m_lane[k][s] = d[SW-1:0];
                end
                check_all(s == 16 ? "R3 broadcast" : (s < NL ? "R2 single" : "R5 reserved"));
            end
        end

        // R4: upper bits dropped, select has no effect on reads
        wr(3'd0, 32'h2);
        wr(3'd2, 32'hABCD_1234);
        m_sh[1] = 16'h1234; m_lane[1][2] = 16'h1234;
        wr(3'd0, 32'h1F);
        check_all("R4 read after select change");

        // R6: read-only bits and unused addresses
        wr(3'd0, 32'hFFFF_FFC3);
        rd(3'd0, r);
        check("R6 ro bits", 64'(r), 64'h3);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, r); check("R6 addr5", 64'(r), 64'h0);
        rd(3'd6, r); check("R6 addr6", 64'(r), 64'h0);
        rd(3'd7, r); check("R6 addr7", 64'(r), 64'h0);
        check_all("R6 unused write");

        // R7: power down
        wr(3'd0, 32'h30);
        pwr_check("R7 down", 4'hF, 1'b1, 1'b1, 1'b0);
        rd(3'd0, r);
        check("R6 pd bit", 64'(r), 64'h30);

        // R9: no training without lock
        cmu_lock = 1'b0;
        wr(3'd0, 32'h10);
        pwr_check("R8 wake outputs", 4'h0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 2 * WC; i++) begin
            @(negedge clk);
            check("R9 no lock", 64'(train_req), 64'h0);
        end
        cmu_lock = 1'b1;
        @(negedge clk);
        check("R9 lock pulse", 64'(train_req), 64'h1);
        @(negedge clk);
        check("R9 pulse end", 64'(train_req), 64'h0);

        // R8: exact pulse cycle with lock high
        wr(3'd0, 32'h30);
        wr(3'd0, 32'h10);
        for (int n = 0; n <= WC + 2; n++) begin
            check("R8 pulse timing", 64'(train_req), 64'(n == WC));
            @(negedge clk);
        end
        pwr_check("R8 up", 4'h0, 1'b0, 1'b0, 1'b0);

        // R10: external hold
        ext_hold = 1'b1;
        @(negedge clk);
        pwr_check("R10 held", 4'hF, 1'b1, 1'b0, 1'b0);
        wr(3'd0, 32'h30);
        pwr_check("R10 set ignored", 4'hF, 1'b1, 1'b0, 1'b0);
        wr(3'd0, 32'h10);
        pwr_check("R10 clear ignored", 4'hF, 1'b1, 1'b0, 1'b0);
        wr(3'd0, 32'h30);
        ext_hold = 1'b0;
        @(negedge clk);
        pwr_check("R10 release to down", 4'hF, 1'b1, 1'b1, 1'b0);
        ext_hold = 1'b1;
        wr(3'd0, 32'h10);
        ext_hold = 1'b0;
        @(negedge clk);
        pwr_check("R10 release to wake", 4'h0, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule